// File: doc/BRIEF.md
# Gray-Count Ramp Converter Digital Backend

This block is the digital half of a multichannel single-slope (ramp-compare) converter. A single counter, shared by every channel, counts in Gray code while an external analog ramp rises. The counter and the ramp are restarted together when a conversion is requested. Each channel brings in one asynchronous comparator output, which flips once the ramp passes the difference of the two voltages sampled for that channel. On that flip the channel freezes the Gray count it sees. Because only one bit of a Gray code changes per step, a capture cannot land on a torn multi-bit value.

Each comparator passes through a two-flop synchronizer and a rising-edge detector before the capture. Only the first rising edge in a conversion is taken. A channel that never flips receives the full-scale code. When the count reaches its top value, the ramp stops and the block enters readout. It then presents one result per cycle, in ascending channel order, converted to plain binary, with a valid strobe.

The controller is a three-state machine. In `ST_IDLE` no ramp runs. The `start` transition (`conv_start` seen in `ST_IDLE`) clears the counter, re-arms every channel and enters `ST_RAMP`. In `ST_RAMP` the counter advances once per cycle. The `top_out` transition (count at full scale) leads to `ST_SHIFT`, where one channel is read out per cycle. The `last_slot` transition (the last channel has been shown) returns to `ST_IDLE`.

Top module: `wilk_gray_backend`

## Requirements
- R1: After reset, `busy`, `ramp_run` and `rd_valid` are 0 and `cnt_gray` is 0.
- R2: A `conv_start` sampled in idle makes `ramp_run` 1 and `cnt_gray` 0 in the next cycle. k cycles later, `cnt_gray` equals k XOR (k>>1), the Gray code of k.
- R3: While the ramp runs, consecutive values of `cnt_gray` differ in exactly one bit.
- R4: A comparator that rises (0 to 1) in the cycle that follows the k-th clock edge after the start edge yields the binary result k+2. The +2 is the delay of the two synchronizer stages.
- R5: After a channel has captured, further falling or rising edges of its comparator in the same conversion leave its result unchanged.
- R6: A channel whose comparator never rises during the ramp reports full scale, 2^CNT_W-1.
- R7: `ramp_run` stays 1 for exactly 2^CNT_W cycles. In the cycle after it drops, readout has begun.
- R8: Readout shows `rd_valid` for exactly NUM_CH consecutive cycles. `rd_chan` runs 0,1,…,NUM_CH-1, and `rd_data` carries that channel's result in binary. After the last channel, `busy` returns to 0.
- R9: `conv_start` while `busy` is 1 has no effect: the counter is not cleared and the readout is not lengthened.
- R10: A comparator that is already high when the conversion starts has no rising edge, so it reports full scale.
- R11: Channels whose comparators rise in the same cycle report identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_start | input | 1 | Request a conversion (acted on only when idle) |
| cmp_in | input | NUM_CH | Asynchronous comparator outputs, one per channel |
| ramp_run | output | 1 | High while the analog ramp should run |
| cnt_gray | output | CNT_W | Shared Gray-coded count |
| busy | output | 1 | High from start until readout ends |
| rd_valid | output | 1 | Readout strobe |
| rd_chan | output | $clog2(NUM_CH) | Channel number of the current readout item |
| rd_data | output | CNT_W | Binary result of that channel |

## Verification
The bench builds the block with NUM_CH = 6 and the full 10-bit counter. This makes every conversion sweep all 1024 counts, so the terminal-count path and captures on the last counts (results 1022 and 1023) are exercised directly. Six channels are enough to run a simultaneous pair, a re-toggled channel, a channel held high at start and a silent channel in one conversion. They also keep the readout short enough to check item by item against a queue.

// File: rtl/wilk_pkg.sv
package wilk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RAMP  = 2'd1,
        ST_SHIFT = 2'd2
    } wilk_state_e;
endpackage

// File: rtl/wilk_gray_to_bin.sv
module wilk_gray_to_bin #(
    parameter int W = 10
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    // each binary bit is the parity of all Gray bits at or above it
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = ^gray[W-1:i];
    end
endmodule

// File: rtl/wilk_gray_counter.sv
module wilk_gray_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt_gray,
    output logic         at_top
);
    localparam logic [W-1:0] TOP_BIN  = {W{1'b1}};
    localparam logic [W-1:0] TOP_GRAY = TOP_BIN ^ (TOP_BIN >> 1);

    logic [W-1:0] gray_q;
    logic [W-1:0] cur_bin;
    logic [W-1:0] nxt_bin;
    logic [W-1:0] nxt_gray;

    wilk_gray_to_bin #(.W(W)) u_dec (
        .gray (gray_q),
        .bin  (cur_bin)
    );

    always_comb begin
        nxt_bin  = cur_bin + 1'b1;
        nxt_gray = nxt_bin ^ (nxt_bin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   gray_q <= '0;
        else if (clr) gray_q <= '0;
        else if (en)  gray_q <= nxt_gray;
    end

    assign cnt_gray = gray_q;
    assign at_top   = (gray_q == TOP_GRAY);

    assert_one_bit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> ($countones(gray_q ^ $past(gray_q)) == 1));

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (gray_q == '0));
endmodule

// File: rtl/wilk_chan_slot.sv
module wilk_chan_slot #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_async,
    input  logic         arm,
    input  logic         capture_en,
    input  logic         force_full,
    input  logic [W-1:0] cnt_gray,
    output logic [W-1:0] code_gray,
    output logic         done
);
    localparam logic [W-1:0] FULL_BIN  = {W{1'b1}};
    localparam logic [W-1:0] FULL_GRAY = FULL_BIN ^ (FULL_BIN >> 1);

    logic meta_q, sync_q, prev_q;
    logic rise;
    logic [W-1:0] code_q;
    logic done_q;

    // two-stage synchronizer plus one stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= cmp_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            done_q <= 1'b0;
        end else if (arm) begin
            code_q <= '0;
            done_q <= 1'b0;
        end else if (capture_en && !done_q) begin
            if (rise) begin
                code_q <= cnt_gray;
                done_q <= 1'b1;
            end else if (force_full) begin
                code_q <= FULL_GRAY;
                done_q <= 1'b1;
            end
        end
    end

    assign code_gray = code_q;
    assign done      = done_q;

    assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !arm) |=> (code_q == $past(code_q)));
endmodule

// File: rtl/wilk_gray_backend.sv
module wilk_gray_backend #(
    parameter int NUM_CH = 32,
    parameter int CNT_W  = 10,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic [NUM_CH-1:0] cmp_in,
    output logic              ramp_run,
    output logic [CNT_W-1:0]  cnt_gray,
    output logic              busy,
    output logic              rd_valid,
    output logic [CH_W-1:0]   rd_chan,
    output logic [CNT_W-1:0]  rd_data
);
    import wilk_pkg::*;

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    wilk_state_e state_q, state_d;
    logic [CH_W-1:0] idx_q, idx_d;

    logic top_hit;
    logic arm;
    logic in_ramp;
    logic [CNT_W-1:0] slot_code [NUM_CH];
    logic [NUM_CH-1:0] slot_done;
    logic [CNT_W-1:0] sel_gray;
    logic [CNT_W-1:0] sel_bin;

    assign in_ramp = (state_q == ST_RAMP);
    assign arm     = (state_q == ST_IDLE) && conv_start;

    wilk_gray_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (arm),
        .en       (in_ramp && !top_hit),
        .cnt_gray (cnt_gray),
        .at_top   (top_hit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        wilk_chan_slot #(.W(CNT_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmp_async  (cmp_in[c]),
            .arm        (arm),
            .capture_en (in_ramp),
            .force_full (in_ramp && top_hit),
            .cnt_gray   (cnt_gray),
            .code_gray  (slot_code[c]),
            .done       (slot_done[c])
        );
    end

    assign sel_gray = slot_code[idx_q];

    wilk_gray_to_bin #(.W(CNT_W)) u_rd_dec (
        .gray (sel_gray),
        .bin  (sel_bin)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (conv_start) state_d = ST_RAMP;        // start
            end
            ST_RAMP: begin
                if (top_hit) begin                        // top_out
                    state_d = ST_SHIFT;
                    idx_d   = '0;
                end
            end
            ST_SHIFT: begin
                if (idx_q == LAST_CH) state_d = ST_IDLE;  // last_slot
                else                  idx_d   = idx_q + 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // outputs
    always_comb begin
        ramp_run = (state_q == ST_RAMP);
        busy     = (state_q != ST_IDLE);
        rd_valid = (state_q == ST_SHIFT);
        rd_chan  = idx_q;
        rd_data  = sel_bin;
    end

    assert_shift_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_chan != LAST_CH) |=> (rd_valid && rd_chan == $past(rd_chan) + 1'b1));

    assert_ramp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_run && !top_hit) |=> ramp_run);

    assert_top_to_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_run && top_hit) |=> (rd_valid && rd_chan == '0));

    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_run && conv_start) |=> (cnt_gray != '0));

    assert_all_done_at_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (&slot_done));
endmodule

// File: tb/wilk_gray_backend_bench.sv
module wilk_gray_backend_bench;
    localparam int NUM_CH = 6;
    localparam int CNT_W  = 10;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int TOP    = (1 << CNT_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              conv_start = 1'b0;
    logic [NUM_CH-1:0] cmp_in = '0;
    logic              ramp_run;
    logic [CNT_W-1:0]  cnt_gray;
    logic              busy;
    logic              rd_valid;
    logic [CH_W-1:0]   rd_chan;
    logic [CNT_W-1:0]  rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    int     exp_ch[$];
    int     exp_code[$];
    string  exp_tag[$];

    always #5 clk = ~clk;

    wilk_gray_backend #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_wilk_gray_backend (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .cmp_in     (cmp_in),
        .ramp_run   (ramp_run),
        .cnt_gray   (cnt_gray),
        .busy       (busy),
        .rd_valid   (rd_valid),
        .rd_chan    (rd_chan),
        .rd_data    (rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: pop the scoreboard for each readout item
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_ch.size() == 0) begin
                chk(1'b0, "R8 unexpected item", int'(rd_chan), -1);
            end else begin
                int    ech;
                int    ecode;
                string etag;
                ech   = exp_ch.pop_front();
                ecode = exp_code.pop_front();
                etag  = exp_tag.pop_front();
                chk(int'(rd_chan) == ech, "R8 channel order", int'(rd_chan), ech);
                chk(int'(rd_data) == ecode, etag, int'(rd_data), ecode);
            end
        end
    end

    // rise_j: cycle index after start edge at which the comparator rises,
    // -1 never, -2 already high before start
    task automatic run_conv(input int rise_j [NUM_CH], input int tog_ch,
                            input int tog_down, input int tog_up,
                            input int busy_start_j);
        logic [CNT_W-1:0] prev;
        prev = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            int    e;
            string t;
            cmp_in[c] = (rise_j[c] == -2);
            if (rise_j[c] < 0 || rise_j[c] + 2 > TOP - 1) e = TOP - 1;
            else e = rise_j[c] + 2;
            if (rise_j[c] == -2)      t = "R10 high at start";
            else if (rise_j[c] == -1) t = "R6 full scale";
            else if (c == tog_ch)     t = "R5 retoggle ignored";
            else                      t = "R4/R11 captured code";
            exp_ch.push_back(c);
            exp_code.push_back(e);
            exp_tag.push_back(t);
        end
        repeat (4) @(posedge clk);
        #1 conv_start = 1'b1;
        @(posedge clk);
        #1 conv_start = 1'b0;
        for (int j = 0; j <= TOP + NUM_CH; j++) begin
            if (j < TOP) begin
                chk(cnt_gray == CNT_W'(j ^ (j >> 1)), "R2 count value", int'(cnt_gray), j ^ (j >> 1));
                chk(ramp_run == 1'b1, "R7 ramp running", int'(ramp_run), 1);
                if (j > 0)
                    chk($countones(cnt_gray ^ prev) == 1, "R3 single bit step",
                        $countones(cnt_gray ^ prev), 1);
                prev = cnt_gray;
            end else if (j == TOP) begin
                chk(!ramp_run && rd_valid, "R7 ramp end to readout", int'(ramp_run), 0);
            end else if (j == TOP + NUM_CH) begin
                chk(!busy && !rd_valid, "R9 R8 idle after readout", int'(busy), 0);
                chk(exp_ch.size() == 0, "R8 all items read", exp_ch.size(), 0);
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (rise_j[c] == j) cmp_in[c] = 1'b1;
                if (c == tog_ch && j == tog_down) cmp_in[c] = 1'b0;
                if (c == tog_ch && j == tog_up)   cmp_in[c] = 1'b1;
            end
            conv_start = (j == busy_start_j);
            @(posedge clk);
            #1;
        end
        cmp_in     = '0;
        conv_start = 1'b0;
    endtask

    initial begin
        int p1 [NUM_CH];
        int p2 [NUM_CH];
        int p3 [NUM_CH];
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !ramp_run && !rd_valid && cnt_gray == '0, "R1 reset state", int'(busy), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(!busy && cnt_gray == '0, "R1 idle after reset", int'(cnt_gray), 0);

        p1 = '{0, 498, -1, 1021, 98, 98};          // R4 R6 R11, code 1023 at last count
        run_conv(p1, -1, -1, -1, -1);

        p2 = '{-2, 10, 1020, 1, -1, 775};          // R10 R5 R9 R4 R6
        run_conv(p2, 1, 20, 30, 50);

        p3 = '{5, 0, 300, 600, 900, 1019};
        run_conv(p3, -1, -1, -1, -1);

        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !rd_valid, "R9 stays idle", int'(busy), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule